// File: doc/BRIEF.md
# Video Timing Pattern Generator

The block produces the timing signals of a raster video stream from a pixel clock: horizontal sync, vertical sync and data-enable. When colour bars are selected, it also produces a pixel colour during the active region. Every pixel clock cycle advances the horizontal counter by one. The vertical counter advances once per line. Sync, data-enable and colour are decoded from these two counters.

Software programs the frame geometry through a small byte-wide write port with three addresses. The first address holds an index. The second address writes a byte into the timing register that the index selects. The third address is a control byte that starts and stops generation and turns colour bars on or off. The four 12-bit sizes (total and active width and height) are spread over three byte registers per width/height pair. The middle byte of each triple carries one nibble of each size.

Timing register writes go to a shadow copy. The live geometry takes the shadow values only while the generator is stopped or at the wrap into a new frame, so a frame is never drawn with mixed geometry. The design assumes a horizontal sync width of at least one pixel and an active width of at least eight pixels.

Top module: `video_timing_patgen`

## Requirements
- R1: `wr_addr`=0 stores `wr_data` as the index, and `wr_addr`=1 writes `wr_data` into the timing register that the index selects. `wr_addr`=2 writes the control byte: bit 0 enables generation and bit 2 selects colour bars.
- R2: 12-bit sizes are packed in byte triples. Index 0x04 holds total width [7:0], index 0x05 holds total width [11:8] in bits 3:0 and total height [3:0] in bits 7:4, and index 0x06 holds total height [11:4]. Indices 0x07, 0x08 and 0x09 hold active width and active height in the same layout.
- R3: Index 0x0A sets the horizontal sync width in pixels and index 0x0B sets the vertical sync width in lines. Index 0x0C sets the horizontal back porch in pixels and index 0x0D sets the vertical back porch in lines. All four are 8-bit values.
- R4: A line lasts total-width cycles, ordered as sync (pixels 0 to hsw-1), back porch, active pixels, then front porch. A frame lasts total-height lines with the same order in lines. Sync is asserted during its region only.
- R5: `de` is high exactly when the horizontal position and the vertical line both lie in their active regions.
- R6: Index 0x0E sets the sync polarity. Bit 0 set makes `hsync` active-low and bit 1 set makes `vsync` active-low. A value of 0 makes both active-high.
- R7: With bars selected, active pixel x (counted from 0 at the first active pixel) lies in stripe floor(8*x/active width). Stripes 0 to 7 are white, yellow, cyan, green, magenta, red, blue and black. `rgb` is {red, green, blue} with each channel either all ones or all zeros, and `rgb` is 0 whenever `de` is low.
- R8: With generation enabled and bar select clear, `rgb` stays 0 while `de` still follows the timing.
- R9: Timing register writes made while generating leave the current frame unchanged. They apply from the next frame start.
- R10: While disabled, `de` and `rgb` are 0 and both syncs sit at their inactive level. Writing an enabling control byte puts the counters at pixel 0 of line 0 in the cycle after the write.
- R11: Data writes to any index other than 0x04 to 0x0E change nothing.
- R12: After reset the block is disabled, every timing register and the polarity are 0, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | 0 index, 1 data, 2 control |
| wr_data | input | 8 | Write byte |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| rgb | output | 3*CW | Pixel colour {red, green, blue} |

## Verification
The checker watches every cycle for the following:
- the counters stay inside the live frame;
- the live geometry stays constant between frame starts;
- the outputs are idle while disabled;
- colour appears only with `de`;
- sync never overlaps `de`;
- each active line opens with a white pixel when bars are on.

The exact position of every sync edge, porch and stripe boundary can only be shown by the bench's sweeps, and so can the nibble packing of sizes above 255. The sweeps compare every pixel of whole frames against an arithmetic model. They also cover a geometry change written in the middle of a frame, which the model expects to appear one frame later.

// File: rtl/video_timing_patgen.sv
module video_timing_patgen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [7:0]    wr_data,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [3*CW-1:0] rgb
);
  localparam int SZW = 12;
  localparam int BW  = 8;
  localparam int EXW = SZW + 2;

  logic [BW-1:0]  idx;
  logic           ctl_en, ctl_bars;
  logic [SZW-1:0] s_tw, s_th, s_aw, s_ah;
  logic [BW-1:0]  s_hsw, s_vsw, s_hbp, s_vbp;
  logic [1:0]     s_pol;

  logic [SZW-1:0] l_tw, l_th, l_aw, l_ah;
  logic [BW-1:0]  l_hsw, l_vsw, l_hbp, l_vbp;
  logic [1:0]     l_pol;

  logic [SZW-1:0] h_cnt, v_cnt;
  logic [SZW:0]   bar_acc;
  logic [2:0]     bar_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0; ctl_en <= 1'b0; ctl_bars <= 1'b0;
      s_tw <= '0; s_th <= '0; s_aw <= '0; s_ah <= '0;
      s_hsw <= '0; s_vsw <= '0; s_hbp <= '0; s_vbp <= '0;
      s_pol <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: idx <= wr_data;
        2'd1: begin
          case (idx)
            8'h04: s_tw[7:0] <= wr_data;
            8'h05: begin s_tw[11:8] <= wr_data[3:0]; s_th[3:0] <= wr_data[7:4]; end
            8'h06: s_th[11:4] <= wr_data;
            8'h07: s_aw[7:0] <= wr_data;
            8'h08: begin s_aw[11:8] <= wr_data[3:0]; s_ah[3:0] <= wr_data[7:4]; end
            8'h09: s_ah[11:4] <= wr_data;
            8'h0A: s_hsw <= wr_data;
            8'h0B: s_vsw <= wr_data;
            8'h0C: s_hbp <= wr_data;
            8'h0D: s_vbp <= wr_data;
            8'h0E: s_pol <= wr_data[1:0];
            default: ;
          endcase
        end
        2'd2: begin ctl_en <= wr_data[0]; ctl_bars <= wr_data[2]; end
        default: ;
      endcase
    end
  end

  logic h_last, v_last;
  assign h_last = ({1'b0, h_cnt} + 13'd1) >= {1'b0, l_tw};
  assign v_last = ({1'b0, v_cnt} + 13'd1) >= {1'b0, l_th};

  logic [EXW-1:0] h_start, h_end, v_start, v_end;
  assign h_start = {6'b0, l_hsw} + {6'b0, l_hbp};
  assign h_end   = h_start + {2'b0, l_aw};
  assign v_start = {6'b0, l_vsw} + {6'b0, l_vbp};
  assign v_end   = v_start + {2'b0, l_ah};

  logic hs_on, vs_on, h_act, v_act;
  assign hs_on = h_cnt < {4'b0, l_hsw};
  assign vs_on = v_cnt < {4'b0, l_vsw};
  assign h_act = ({2'b0, h_cnt} >= h_start) && ({2'b0, h_cnt} < h_end);
  assign v_act = ({2'b0, v_cnt} >= v_start) && ({2'b0, v_cnt} < v_end);

  logic [SZW:0] bar_sum;
  assign bar_sum = bar_acc + 13'd8;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_cnt <= '0; v_cnt <= '0; bar_acc <= '0; bar_idx <= '0;
      l_tw <= '0; l_th <= '0; l_aw <= '0; l_ah <= '0;
      l_hsw <= '0; l_vsw <= '0; l_hbp <= '0; l_vbp <= '0; l_pol <= '0;
    end else if (!ctl_en) begin
      h_cnt <= '0; v_cnt <= '0; bar_acc <= '0; bar_idx <= '0;
      l_tw <= s_tw; l_th <= s_th; l_aw <= s_aw; l_ah <= s_ah;
      l_hsw <= s_hsw; l_vsw <= s_vsw; l_hbp <= s_hbp; l_vbp <= s_vbp; l_pol <= s_pol;
    end else begin
      if (h_last) begin
        h_cnt <= '0;
        v_cnt <= v_last ? '0 : v_cnt + 1'b1;
        if (v_last) begin
          l_tw <= s_tw; l_th <= s_th; l_aw <= s_aw; l_ah <= s_ah;
          l_hsw <= s_hsw; l_vsw <= s_vsw; l_hbp <= s_hbp; l_vbp <= s_vbp; l_pol <= s_pol;
        end
      end else begin
        h_cnt <= h_cnt + 1'b1;
      end
      if (!h_act) begin
        bar_acc <= '0;
        bar_idx <= '0;
      end else if (bar_sum >= {1'b0, l_aw}) begin
        bar_acc <= bar_sum - {1'b0, l_aw};
        bar_idx <= bar_idx + 3'd1;
      end else begin
        bar_acc <= bar_sum;
      end
    end
  end

  assign hsync = (ctl_en & hs_on) ^ l_pol[0];
  assign vsync = (ctl_en & vs_on) ^ l_pol[1];
  assign de    = ctl_en & h_act & v_act;
  assign rgb   = (de && ctl_bars) ? {{CW{~bar_idx[1]}}, {CW{~bar_idx[2]}}, {CW{~bar_idx[0]}}}
                                  : '0;
endmodule

// File: rtl/video_timing_patgen_chk.sv
module video_timing_patgen_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          bars,
  input logic [1:0]    pol,
  input logic [11:0]   h,
  input logic [11:0]   v,
  input logic [11:0]   tw,
  input logic [11:0]   th,
  input logic [11:0]   aw,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic [3*CW-1:0] rgb
);
  // R10
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!de && rgb == '0));

  // R4
  h_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tw != '0) |-> (h < tw));

  // R4
  v_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && th != '0) |-> (v < th));

  // R9
  frame_geom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !(h == '0 && v == '0)) |-> ($stable(tw) && $stable(th) && $stable(aw)));

  // R7
  colour_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb != '0) |-> de);

  // R4
  hsync_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync != pol[0]) |-> !de);

  // R5
  vsync_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync != pol[1]) |-> !de);

  // R7
  first_white_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(de) && bars) |-> (rgb == '1));
endmodule

bind video_timing_patgen video_timing_patgen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctl_en), .bars(ctl_bars), .pol(l_pol),
  .h(h_cnt), .v(v_cnt), .tw(l_tw), .th(l_th), .aw(l_aw),
  .hsync(hsync), .vsync(vsync), .de(de), .rgb(rgb)
);

// File: tb/video_timing_patgen_bench.sv
`timescale 1ns/1ps
module video_timing_patgen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic hsync, vsync, de;
  logic [23:0] rgb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int tw, th, aw, ah, hsw, vsw, hbp, vbp, pol;
  } cfg_t;

  cfg_t cur, pend, cfg_a, cfg_b, cfg_c;

  video_timing_patgen u_video_timing_patgen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .de(de), .rgb(rgb)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] i, input logic [7:0] d);
    wr(2'd0, i);
    wr(2'd1, d);
  endtask

  task automatic prog(input cfg_t c);
    logic [11:0] tw, th, aw, ah;
    tw = c.tw[11:0]; th = c.th[11:0]; aw = c.aw[11:0]; ah = c.ah[11:0];
    wreg(8'h06, th[11:4]);
    wreg(8'h04, tw[7:0]);
    wreg(8'h05, {th[3:0], tw[11:8]});
    wreg(8'h09, ah[11:4]);
    wreg(8'h07, aw[7:0]);
    wreg(8'h08, {ah[3:0], aw[11:8]});
    wreg(8'h0A, c.hsw[7:0]);
    wreg(8'h0C, c.hbp[7:0]);
    wreg(8'h0B, c.vsw[7:0]);
    wreg(8'h0D, c.vbp[7:0]);
    wreg(8'h0E, c.pol[7:0]);
    pend = c;
  endtask

  function automatic logic [23:0] bar_colour(input int s);
    case (s)
      0: return 24'hFFFFFF;
      1: return 24'hFFFF00;
      2: return 24'h00FFFF;
      3: return 24'h00FF00;
      4: return 24'hFF00FF;
      5: return 24'hFF0000;
      6: return 24'h0000FF;
      default: return 24'h000000;
    endcase
  endfunction

  task automatic check_px(input int h, input int v, input bit bars_on);
    bit ehs, evs, ehact, evact, ede;
    logic [23:0] ergb;
    int hb, vb;
    hb = cur.hsw + cur.hbp;
    vb = cur.vsw + cur.vbp;
    ehs = (h < cur.hsw) ^ cur.pol[0];
    evs = (v < cur.vsw) ^ cur.pol[1];
    ehact = (h >= hb) && (h < hb + cur.aw);
    evact = (v >= vb) && (v < vb + cur.ah);
    ede = ehact && evact;
    ergb = (ede && bars_on) ? bar_colour((8 * (h - hb)) / cur.aw) : 24'h0;
    // R2 R3 R4 R6: sync positions and levels
    chk({hsync, vsync} == {ehs, evs}, "R4 R6", $sformatf("sync h=%0d v=%0d", h, v),
        {30'b0, hsync, vsync}, {30'b0, ehs, evs});
    // R5: data enable region
    chk(de == ede, "R5", $sformatf("de h=%0d v=%0d", h, v), {31'b0, de}, {31'b0, ede});
    // R7 R8: colour bars or black
    chk(rgb == ergb, bars_on ? "R7" : "R8", $sformatf("rgb h=%0d v=%0d", h, v),
        {8'b0, rgb}, {8'b0, ergb});
  endtask

  task automatic sweep(input int frames, input bit bars_on);
    for (int f = 0; f < frames; f++) begin
      cur = pend;
      for (int v = 0; v < cur.th; v++) begin
        for (int h = 0; h < cur.tw; h++) begin
          check_px(h, v, bars_on);
          @(negedge clk);
        end
      end
    end
  endtask

  task automatic check_idle(input string req, input int pol);
    logic [3:0] exp;
    exp = {pol[0], pol[1], 2'b00};
    chk({hsync, vsync, de, (rgb != 0)} == exp, req, "idle outputs",
        {28'b0, hsync, vsync, de, (rgb != 0)}, {28'b0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cfg_a = '{tw:22,  th:6,   aw:16,  ah:3,   hsw:2, vsw:1, hbp:1,  vbp:1, pol:0};
    cfg_b = '{tw:300, th:5,   aw:260, ah:2,   hsw:4, vsw:1, hbp:10, vbp:1, pol:1};
    cfg_c = '{tw:12,  th:270, aw:8,   ah:258, hsw:1, vsw:3, hbp:1,  vbp:4, pol:2};

    repeat (3) @(negedge clk);
    // R12: reset state
    check_idle("R12", 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R12", 0);

    // R1 R2 R3 R11: program A with stray writes to unlisted indices
    wreg(8'h03, 8'hFF);
    prog(cfg_a);
    wreg(8'h0F, 8'hFF);
    wreg(8'h10, 8'h33);
    // R10: still disabled after programming
    check_idle("R10", 0);

    // R10: enable with bars, first checked cycle is pixel 0 of line 0
    wr(2'd2, 8'h05);
    // R9: geometry B written in the middle of the first frame of A
    fork
      sweep(3, 1'b1);
      begin
        repeat (40) @(negedge clk);
        prog(cfg_b);
      end
    join

    // R10 R6: disable, outputs idle at the inactive levels of B
    wr(2'd2, 8'h00);
    check_idle("R10 R6", cfg_b.pol);
    @(negedge clk);
    check_idle("R10 R6", cfg_b.pol);

    // R11: unlisted indices around geometry C
    wreg(8'h00, 8'h5A);
    prog(cfg_c);
    wreg(8'h1E, 8'h77);
    check_idle("R10 R6", cfg_c.pol);

    // R8: enabled without bars
    wr(2'd2, 8'h01);
    sweep(1, 1'b0);

    // R7: bars with one pixel per stripe, restart from pixel 0
    wr(2'd2, 8'h00);
    @(negedge clk);
    wr(2'd2, 8'h05);
    sweep(1, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule